// File: doc/BRIEF.md
# Bus-Cycle Trace Capture Buffer

This block is a capture unit for an 8-bit CPU bus with a 16-bit address, in the manner of a small logic analyser. Each valid bus cycle can be stored as five bytes in five parallel circular banks: address high, address low, write data, read data and a control byte. A trigger compares the observed address, data and control against a comparator pattern. Only the bits selected by a qualifier mask take part in that comparison. Depending on the mode, the trigger either opens a capture window or closes one.

Software configures the unit through a nine-byte register file on one chip select. It reads the captured history through a second chip select, and a bank-select register picks which of the five banks is returned. The read offset is rotated by the capture write pointer, so offset 0 is the oldest stored cycle once the buffer has filled. A sticky status bit records the trigger, and an interrupt output reports it when enabled.

Top module: `bus_trace_top`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low, and `cpu_rdata` is 0x00 while neither chip select is active.
- R2: Register index is `cpu_addr[3:0]`: 0 compare-addr-high, 1 compare-addr-low, 2 compare-data, 3 compare-control, 4 mask-addr-high, 5 mask-addr-low, 6 mask-data, 7 mask-control, 8 bank select (3 bits, upper bits read 0). Register reads are combinational. Mask-control bit 7 reads the trigger status, and bits 6..0 read as written.
- R3: A trigger hit needs `bus_vma`=1 and equality on every masked bit of the 32-bit vector {bus_addr, data, control}. Data is `bus_din` when `bus_rw`=1 and `bus_dout` when `bus_rw`=0. The control byte is {6'b0, bus_vma, bus_rw}, and only mask bits 1..0 of mask-control apply.
- R4: Start mode (mask-control bit 6 = 0): nothing is captured until the hit cycle. The hit cycle and the next 2^AW-1 valid cycles are then captured, and capture stops.
- R5: Stop mode (mask-control bit 6 = 1): every valid cycle after arming is captured. The hit cycle is the last one captured.
- R6: A buffer read at offset k returns the entry at (k + write pointer) mod 2^AW, one clock after the address is presented. Bank select 0..4 returns address-high, address-low, write data, read data or control. Other codes return 0x00.
- R7: A hit sets the status bit. `irq` equals status AND mask-control bit 5.
- R8: Any register write re-arms the trigger and clears status. In the same cycle, a bus cycle is neither evaluated nor captured.
- R9: Writes under the buffer chip select leave the banks unchanged.
- R10: Cycles with `bus_vma`=0 are never captured and never trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_cs | input | 1 | Register file select |
| buf_cs | input | 1 | Trace bank select |
| cpu_we | input | 1 | Write strobe for the access port |
| cpu_addr | input | AW | Register index or buffer offset |
| cpu_wdata | input | 8 | Write data of the access port |
| cpu_rdata | output | 8 | Read data of the access port |
| bus_addr | input | 16 | Observed bus address |
| bus_dout | input | 8 | Observed CPU write data |
| bus_din | input | 8 | Observed CPU read data |
| bus_rw | input | 1 | Observed read/write strobe (1 = read) |
| bus_vma | input | 1 | Observed valid-cycle strobe |
| irq | output | 1 | Trigger interrupt |

## Verification
A register write and a qualifying bus cycle can fall in the same clock. The write must win: it re-arms the trigger and drops the bus cycle. The bench forces this in stop mode by writing the bank-select register while presenting the trigger address with a read strobe. It then checks that `irq` stays low and that status reads back clear. It also checks the buffer readout: offset 510 must hold the last pre-collision cycle and offset 511 the later genuine trigger, which shows the colliding cycle was never stored.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int NBANK = 5;

    localparam logic [3:0] RA_CAH = 4'd0;
    localparam logic [3:0] RA_CAL = 4'd1;
    localparam logic [3:0] RA_CDT = 4'd2;
    localparam logic [3:0] RA_CCT = 4'd3;
    localparam logic [3:0] RA_MAH = 4'd4;
    localparam logic [3:0] RA_MAL = 4'd5;
    localparam logic [3:0] RA_MDT = 4'd6;
    localparam logic [3:0] RA_MCT = 4'd7;
    localparam logic [3:0] RA_BSL = 4'd8;

    localparam int CTL_STAT  = 7;
    localparam int CTL_STOP  = 6;
    localparam int CTL_IRQEN = 5;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  ctl;
    } pat_t;

    typedef struct packed {
        pat_t       cmp;
        pat_t       msk;
        logic [2:0] bsel;
    } cfg_t;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] rd;
        logic [7:0] wd;
        logic [7:0] alo;
        logic [7:0] ahi;
    } rec_t;

    typedef enum logic [1:0] {ST_WAIT, ST_POST, ST_PRE, ST_DONE} cap_st_t;

    function automatic logic [7:0] ctl_byte(input logic rw, input logic vma);
        return {6'b0, vma, rw};
    endfunction

endpackage

// File: rtl/trace_regs.sv
module trace_regs
    import trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] idx,
    input  logic [7:0] wdata,
    input  logic       status,
    output cfg_t       cfg,
    output logic [7:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (idx)
                RA_CAH:  cfg.cmp.addr[15:8] <= wdata;
                RA_CAL:  cfg.cmp.addr[7:0]  <= wdata;
                RA_CDT:  cfg.cmp.data       <= wdata;
                RA_CCT:  cfg.cmp.ctl        <= wdata;
                RA_MAH:  cfg.msk.addr[15:8] <= wdata;
                RA_MAL:  cfg.msk.addr[7:0]  <= wdata;
                RA_MDT:  cfg.msk.data       <= wdata;
                RA_MCT:  cfg.msk.ctl        <= {1'b0, wdata[6:0]};
                RA_BSL:  cfg.bsel           <= wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            RA_CAH:  rd_data = cfg.cmp.addr[15:8];
            RA_CAL:  rd_data = cfg.cmp.addr[7:0];
            RA_CDT:  rd_data = cfg.cmp.data;
            RA_CCT:  rd_data = cfg.cmp.ctl;
            RA_MAH:  rd_data = cfg.msk.addr[15:8];
            RA_MAL:  rd_data = cfg.msk.addr[7:0];
            RA_MDT:  rd_data = cfg.msk.data;
            RA_MCT:  rd_data = {status | cfg.msk.ctl[CTL_STAT], cfg.msk.ctl[6:0]};
            RA_BSL:  rd_data = {5'b0, cfg.bsel};
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/trace_trigger.sv
module trace_trigger
    import trace_pkg::*;
(
    input  pat_t        cmp,
    input  pat_t        msk,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_dout,
    input  logic [7:0]  bus_din,
    input  logic        bus_rw,
    input  logic        bus_vma,
    output logic        hit
);
    pat_t seen;
    pat_t eff_msk;

    always_comb begin
        seen.addr    = bus_addr;
        seen.data    = bus_rw ? bus_din : bus_dout;
        seen.ctl     = ctl_byte(bus_rw, bus_vma);
        eff_msk      = msk;
        eff_msk.ctl  = msk.ctl & 8'h03;
        hit          = bus_vma && (((seen ^ cmp) & eff_msk) == '0);
    end
endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rearm,
    input  logic          stop_nxt,
    input  logic          bus_vma,
    input  logic          hit,
    output logic          cap_we,
    output logic [AW-1:0] wr_ptr,
    output logic          status,
    output cap_st_t       st
);
    localparam logic [AW-1:0] POST_LEN = {AW{1'b1}};
    localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] left;

    always_comb begin
        cap_we = !rearm && bus_vma &&
                 ((st == ST_PRE) || (st == ST_POST) || (st == ST_WAIT && hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_WAIT;
            wr_ptr <= '0;
            status <= 1'b0;
            left   <= '0;
        end else if (rearm) begin
            st     <= stop_nxt ? ST_PRE : ST_WAIT;
            status <= 1'b0;
        end else begin
            if (cap_we) wr_ptr <= wr_ptr + ONE;
            case (st)
                ST_WAIT: if (hit) begin
                    st     <= ST_POST;
                    status <= 1'b1;
                    left   <= POST_LEN;
                end
                ST_POST: if (bus_vma) begin
                    left <= left - ONE;
                    if (left == ONE) st <= ST_DONE;
                end
                ST_PRE: if (hit) begin
                    status <= 1'b1;
                    st     <= ST_DONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trace_bank.sv
module trace_bank #(
    parameter int AW = 9,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  q
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        q <= mem[raddr];
    end
endmodule

// File: rtl/bus_trace_top.sv
module bus_trace_top
    import trace_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_cs,
    input  logic          buf_cs,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    input  logic [15:0]   bus_addr,
    input  logic [7:0]    bus_dout,
    input  logic [7:0]    bus_din,
    input  logic          bus_rw,
    input  logic          bus_vma,
    output logic          irq
);
    logic                     reg_wr;
    cfg_t                     cfg;
    logic [7:0]               reg_rd;
    logic                     hit;
    logic                     cap_we;
    logic                     trig_stat;
    cap_st_t                  cap_st;
    logic [AW-1:0]            wr_ptr;
    logic [AW-1:0]            rd_addr;
    logic                     stop_nxt;
    rec_t                     rec;
    logic [NBANK-1:0][7:0]    rec_v;
    logic [NBANK-1:0][7:0]    bank_q;
    logic [7:0]               bank_o;

    assign reg_wr   = reg_cs & cpu_we;
    assign stop_nxt = (reg_wr && cpu_addr[3:0] == RA_MCT) ? cpu_wdata[CTL_STOP]
                                                          : cfg.msk.ctl[CTL_STOP];

    trace_regs regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .idx(cpu_addr[3:0]),
        .wdata(cpu_wdata), .status(trig_stat), .cfg(cfg), .rd_data(reg_rd)
    );

    trace_trigger trig_i (
        .cmp(cfg.cmp), .msk(cfg.msk), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_rw(bus_rw), .bus_vma(bus_vma), .hit(hit)
    );

    trace_capture #(.AW(AW)) cap_i (
        .clk(clk), .rst(rst), .rearm(reg_wr), .stop_nxt(stop_nxt),
        .bus_vma(bus_vma), .hit(hit), .cap_we(cap_we), .wr_ptr(wr_ptr),
        .status(trig_stat), .st(cap_st)
    );

    always_comb begin
        rec.ahi = bus_addr[15:8];
        rec.alo = bus_addr[7:0];
        rec.wd  = bus_dout;
        rec.rd  = bus_din;
        rec.ctl = ctl_byte(bus_rw, bus_vma);
        rec_v   = rec;
        rd_addr = cpu_addr + wr_ptr;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        trace_bank #(.AW(AW), .W(8)) bank_i (
            .clk(clk), .we(cap_we), .waddr(wr_ptr), .wdata(rec_v[b]),
            .raddr(rd_addr), .q(bank_q[b])
        );
    end

    always_comb begin
        bank_o = 8'h00;
        for (int i = 0; i < NBANK; i++)
            if (cfg.bsel == 3'(i)) bank_o = bank_q[i];
        if (reg_cs)      cpu_rdata = reg_rd;
        else if (buf_cs) cpu_rdata = bank_o;
        else             cpu_rdata = 8'h00;
        irq = trig_stat & cfg.msk.ctl[CTL_IRQEN];
    end
endmodule

// File: rtl/trace_chk.sv
module trace_chk
    import trace_pkg::*;
#(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          bus_vma,
    input logic          irq,
    input cap_st_t       st,
    input logic [AW-1:0] ptr,
    input logic          status
);
    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !irq);

    assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> st != ST_DONE);

    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_vma && !reg_wr) |=> ($stable(ptr) && $stable(status)));

    assert_stat_src_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(bus_vma));

    assert_done_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && !reg_wr) |=> (st == ST_DONE && $stable(ptr)));
endmodule

bind bus_trace_top trace_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .bus_vma(bus_vma), .irq(irq),
    .st(cap_st), .ptr(wr_ptr), .status(trig_stat)
);

// File: tb/bus_trace_top_tb_top.sv
module bus_trace_top_tb_top;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_cs = 1'b0, buf_cs = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_dout = '0, bus_din = '0;
    logic          bus_rw = 1'b0, bus_vma = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bus_trace_top #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .reg_cs(reg_cs), .buf_cs(buf_cs), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_rw(bus_rw), .bus_vma(bus_vma), .irq(irq)
    );

    // {index, write value, expected read-back}
    localparam logic [23:0] REGVEC [9] = '{
        24'h00_12_12, 24'h01_34_34, 24'h02_A5_A5, 24'h03_FF_FF, 24'h04_F0_F0,
        24'h05_0F_0F, 24'h06_3C_3C, 24'h07_BF_3F, 24'h08_FB_03
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [15:0] a, input logic [7:0] d_o, input logic [7:0] d_i,
                       input logic rw, input logic vma);
        @(negedge clk);
        bus_addr = a; bus_dout = d_o; bus_din = d_i; bus_rw = rw; bus_vma = vma;
        @(negedge clk);
        bus_vma = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_cs = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(idx); cpu_wdata = d;
        @(negedge clk);
        reg_cs = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] idx, output logic [7:0] v);
        @(negedge clk);
        reg_cs = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(idx);
        @(negedge clk);
        v = cpu_rdata; reg_cs = 1'b0;
    endtask

    task automatic rd_buf(input int off, output logic [7:0] v);
        @(negedge clk);
        buf_cs = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(off);
        @(negedge clk);
        v = cpu_rdata; buf_cs = 1'b0;
    endtask

    // expected bank byte for start-mode entry j (0 = trigger cycle)
    function automatic logic [7:0] exp_start(input int b, input int j);
        logic [15:0] a;
        logic [7:0]  jj;
        jj = 8'(j);
        if (j == 0) begin
            case (b)
                0: return 8'h12; 1: return 8'h34; 2: return 8'h5A;
                3: return 8'hFF; default: return 8'h03;
            endcase
        end
        a = 16'h4000 + 16'(j);
        case (b)
            0: return a[15:8];
            1: return a[7:0];
            2: return jj ^ 8'h5A;
            3: return ~jj;
            default: return {6'b0, 1'b1, jj[0]};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 idle rdata", cpu_rdata, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 9; i++) begin
            rd_reg(4'(i), v);
            chk("R1 reg reset", v, 8'h00);
        end

        // R2 register table walk
        for (int i = 0; i < 9; i++) begin
            wr_reg(REGVEC[i][19:16], REGVEC[i][15:8]);
            rd_reg(REGVEC[i][19:16], v);
            chk("R2 reg readback", v, REGVEC[i][7:0]);
        end

        // start-mode configuration: match 0x1234 on a read
        wr_reg(4'd0, 8'h12); wr_reg(4'd1, 8'h34); wr_reg(4'd2, 8'h00);
        wr_reg(4'd3, 8'h01); wr_reg(4'd4, 8'hFF); wr_reg(4'd5, 8'hFF);
        wr_reg(4'd6, 8'h00); wr_reg(4'd8, 8'h00); wr_reg(4'd7, 8'h21);

        for (int i = 0; i < 10; i++) bus(16'h2000 + 16'(i), 8'(i), 8'(i), 1'b1, 1'b1);
        bus(16'h1234, 8'h11, 8'h22, 1'b0, 1'b1);     // R3 wrong strobe level
        chk("R3 no hit on masked ctl mismatch", {7'b0, irq}, 8'h00);
        bus(16'h1234, 8'h11, 8'h22, 1'b1, 1'b0);     // R10 not valid
        chk("R10 no hit without vma", {7'b0, irq}, 8'h00);

        bus(16'h1234, 8'h5A, 8'hFF, 1'b1, 1'b1);     // trigger
        chk("R7 irq on hit", {7'b0, irq}, 8'h01);
        rd_reg(4'd7, v);
        chk("R7 status bit", v, 8'hA1);

        for (int j = 1; j < DEPTH; j++) begin
            bus(16'h4000 + 16'(j), 8'(j) ^ 8'h5A, ~8'(j), j[0], 1'b1);
            if (j % 3 == 0) bus(16'hFFFF, 8'hEE, 8'hEE, 1'b1, 1'b0); // R10
        end
        for (int i = 0; i < 5; i++) bus(16'h5555, 8'h55, 8'h55, 1'b1, 1'b1); // R4 extra

        // R4/R6 chronological readout of all banks
        for (int b = 0; b < 5; b++) begin
            wr_reg(4'd8, 8'(b));
            for (int k = 0; k < DEPTH; k++) begin
                rd_buf(k, v);
                chk("R4 R6 start window", v, exp_start(b, k));
            end
        end
        wr_reg(4'd8, 8'h05);
        rd_buf(0, v);
        chk("R6 unused bank code", v, 8'h00);

        // R9 buffer writes ignored
        wr_reg(4'd8, 8'h04);
        @(negedge clk);
        buf_cs = 1'b1; cpu_we = 1'b1; cpu_addr = '0; cpu_wdata = 8'h00;
        @(negedge clk);
        buf_cs = 1'b0; cpu_we = 1'b0;
        rd_buf(0, v);
        chk("R9 buffer read-only", v, 8'h03);

        // R5 stop mode, R8 collision
        wr_reg(4'd7, 8'h61);
        chk("R8 irq cleared by write", {7'b0, irq}, 8'h00);
        rd_reg(4'd7, v);
        chk("R8 status cleared", v, 8'h61);
        for (int i = 0; i < 600; i++)
            bus(16'h6000 + 16'(i), 8'(i), 8'(i) ^ 8'hFF, 1'b1, 1'b1);

        @(negedge clk);
        bus_addr = 16'h1234; bus_dout = 8'h77; bus_din = 8'h88; bus_rw = 1'b1; bus_vma = 1'b1;
        reg_cs = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(8); cpu_wdata = 8'h01;
        @(negedge clk);
        bus_vma = 1'b0; reg_cs = 1'b0; cpu_we = 1'b0;
        chk("R8 collision no irq", {7'b0, irq}, 8'h00);
        rd_reg(4'd7, v);
        chk("R8 collision no status", v, 8'h61);

        bus(16'h1234, 8'h5A, 8'hFF, 1'b1, 1'b1);
        chk("R5 irq on stop hit", {7'b0, irq}, 8'h01);
        for (int i = 0; i < 10; i++) bus(16'h7000, 8'h00, 8'h00, 1'b1, 1'b1);

        rd_buf(511, v); chk("R5 last entry is trigger", v, 8'h34);
        rd_buf(510, v); chk("R8 collision not stored", v, 8'h57);
        rd_buf(0, v);   chk("R5 R6 oldest entry", v, 8'h59);
        wr_reg(4'd8, 8'h00);
        rd_buf(0, v);   chk("R5 oldest addr high", v, 8'h60);
        rd_buf(510, v); chk("R5 pre-trigger addr high", v, 8'h62);
        wr_reg(4'd8, 8'h04);
        rd_buf(511, v); chk("R5 trigger control", v, 8'h03);

        // R7 irq disabled, status still set
        wr_reg(4'd7, 8'h41);
        bus(16'h1234, 8'h5A, 8'hFF, 1'b1, 1'b1);
        chk("R7 irq masked", {7'b0, irq}, 8'h00);
        rd_reg(4'd7, v);
        chk("R7 status with irq off", v, 8'hC1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule